// File: doc/BRIEF.md
# Multi-Lane Packet Serial Link

This block carries packets of 128-bit words across a 16-lane serial path and rebuilds them on the far side. On the sending side, words arrive on a ready/valid input. The first word of each packet is a header, and its low nibble gives the number of payload words that follow. Words wait in a queue that is sized in whole packets. Each word is then sent as eight 16-bit slices on successive link cycles. Sending starts as soon as a word is queued, so the rest of the packet does not have to arrive first. The sender writes a CRC-32 into the upper 32 bits of the final word of each packet.

On the receiving side, the slices are put back together into words. The whole packet is held in a packet-sized queue. The CRC of the packet is recomputed and compared with the one received. Only a packet that passes the check is made visible on the ready/valid output. A failing packet is discarded and a sticky error flag is raised. The lane outputs and lane inputs are both pins of the block, so the two sides can be joined directly or through a channel model.

Top module: `lane_pkt_link`

## Requirements
- R1: Each word goes out as 8 link cycles in a row with `link_tx_valid` high. Slice k carries word bits [16k+15:16k], bit i on lane i, and slice 0 is sent first. Idle link cycles happen only between words.
- R2: Header bits [3:0] give the payload word count, from 0 to 8. A packet is the header plus that many words. `out_last` marks the final output word of each packet.
- R3: The sender replaces bits [127:96] of the final word with a CRC-32, and the input values in those bits are ignored. The CRC uses polynomial 0x04C11DB7, starts from all ones, and is shifted MSB-first. It takes in every earlier packet bit, word by word, from bit 0 upward. There is no reflection and no final inversion.
- R4: The lanes start carrying a packet one cycle after its header is accepted, before any payload word has been offered.
- R5: No word of a packet appears on the output until its final word has been received and the CRC has matched.
- R6: A packet whose CRC does not match is dropped whole. The `crc_err` flag then rises and stays high until reset.
- R7: When the input stalls in the middle of a packet, the sender inserts idle link cycles. The receiver skips cycles with `link_rx_valid` low and still rebuilds the packet correctly.
- R8: The send queue holds at most 16 packets. `in_ready` drops when 16 are queued and the next word would be a header.
- R9: The receive queue holds at most 16 packets. A packet that arrives while 16 are held is discarded without raising `crc_err`.
- R10: Packets leave in arrival order. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged.
- R11: After reset, `in_ready` is high, while `out_valid`, `link_tx_valid` and `crc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high |
| in_data | input | 128 | Input word (header or payload) |
| out_valid | output | 1 | Checked output word available |
| out_ready | input | 1 | Output consumer ready |
| out_data | output | 128 | Output word |
| out_last | output | 1 | Final word of the packet |
| link_tx_valid | output | 1 | Lane slice valid this cycle |
| link_tx_data | output | 16 | Lane bits sent |
| link_rx_valid | input | 1 | Received lane slice valid |
| link_rx_data | input | 16 | Lane bits received |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The checks assume three things about the inputs. Every header offered gives a payload count of at most 8. The receive lanes show a slice stream framed exactly as the sending side framed it. Apart from deliberate corruption, nothing is added to the stream or taken away. The bench keeps to these rules: it builds every header with a legal length, and it joins the lanes back to back. The only change it ever makes is an XOR mask applied to whole packets, and that mask touches bit 8 of each slice, never the length nibble.

// File: rtl/lane_pkt_link.sv
module lane_pkt_link #(
  parameter int LANES = 16,
  parameter int WORD_W = 128,
  parameter int LEN_W = 4,
  parameter int MAX_PAY = 8,
  parameter int PKTS = 16,
  parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              link_tx_valid,
  output logic [LANES-1:0]  link_tx_data,
  input  logic              link_rx_valid,
  input  logic [LANES-1:0]  link_rx_data,
  output logic              crc_err
);
  localparam int SLICES = WORD_W / LANES;
  localparam int SIW = $clog2(SLICES);
  localparam int CRC_SL = 32 / LANES;
  localparam int CRC_START = SLICES - CRC_SL;
  localparam int QW = PKTS * (MAX_PAY + 1);
  localparam int PW = $clog2(QW);
  localparam int CW = $clog2(QW + 1);
  localparam int NW = $clog2(PKTS + 1);
  localparam logic [31:0] CRC_INIT = '1;
  localparam logic [SIW-1:0] SL_LAST = SIW'(SLICES - 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [LANES-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < LANES; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QW - 1)) ? '0 : p + PW'(1);
  endfunction

  // ---------------- transmit queue ----------------
  logic [WORD_W-1:0] tq [QW];
  logic [PW-1:0] tq_wp, tq_rp;
  logic [CW-1:0] tq_cnt;
  logic [NW-1:0] tx_pkts;
  logic in_hdr;
  logic [LEN_W-1:0] in_rem;
  logic [LEN_W-1:0] in_len;

  assign in_len = in_data[LEN_W-1:0];
  assign in_ready = (tq_cnt != CW'(QW)) && !(in_hdr && tx_pkts == NW'(PKTS));
  wire in_fire = in_valid && in_ready;

  // ---------------- serializer ----------------
  logic tx_busy, tx_first, tx_nhdr;
  logic [WORD_W-1:0] tx_sh;
  logic [SIW-1:0] tx_sidx, crc_j;
  logic [LEN_W-1:0] tx_rem;
  logic [31:0] tx_crc;
  logic [LANES-1:0] crc_part;

  wire tx_lastw = (tx_rem == '0);
  wire tx_slend = (tx_sidx == SL_LAST);
  wire tx_load = (tq_cnt != '0) && (!tx_busy || tx_slend);
  wire tx_done = tx_busy && tx_slend && tx_lastw;
  wire tx_zone = tx_lastw && (tx_sidx >= SIW'(CRC_START));
  wire [WORD_W-1:0] tq_head = tq[tq_rp];
  assign crc_j = tx_sidx - SIW'(CRC_START);
  assign crc_part = LANES'(tx_crc >> (int'(crc_j) * LANES));
  assign link_tx_valid = tx_busy;
  assign link_tx_data = tx_zone ? crc_part : tx_sh[LANES-1:0];

  always_ff @(posedge clk) begin
    if (in_fire) tq[tq_wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tq_wp <= '0; tq_rp <= '0; tq_cnt <= '0; tx_pkts <= '0;
      in_hdr <= 1'b1; in_rem <= '0;
    end else begin
      if (in_fire) begin
        tq_wp <= nxt(tq_wp);
        if (in_hdr) begin
          in_rem <= in_len;
          in_hdr <= (in_len == '0);
        end else begin
          in_rem <= in_rem - LEN_W'(1);
          in_hdr <= (in_rem == LEN_W'(1));
        end
      end
      if (tx_load) tq_rp <= nxt(tq_rp);
      tq_cnt <= tq_cnt + CW'(in_fire) - CW'(tx_load);
      tx_pkts <= tx_pkts + NW'(in_fire && in_hdr) - NW'(tx_done);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_first <= 1'b0; tx_nhdr <= 1'b1;
      tx_sh <= '0; tx_sidx <= '0; tx_rem <= '0; tx_crc <= CRC_INIT;
    end else begin
      if (tx_busy && !tx_zone)
        tx_crc <= crc_step((tx_first && tx_sidx == '0) ? CRC_INIT : tx_crc, tx_sh[LANES-1:0]);
      if (tx_load) begin
        tx_busy <= 1'b1;
        tx_sh <= tq_head;
        tx_sidx <= '0;
        if (tx_nhdr) begin
          tx_first <= 1'b1;
          tx_rem <= tq_head[LEN_W-1:0];
          tx_nhdr <= (tq_head[LEN_W-1:0] == '0);
        end else begin
          tx_first <= 1'b0;
          tx_rem <= tx_rem - LEN_W'(1);
          tx_nhdr <= (tx_rem == LEN_W'(1));
        end
      end else if (tx_busy) begin
        if (tx_slend) tx_busy <= 1'b0;
        else begin
          tx_sidx <= tx_sidx + SIW'(1);
          tx_sh <= tx_sh >> LANES;
        end
      end
    end
  end

  // R2
  hdr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_hdr |-> in_len <= LEN_W'(MAX_PAY));
  // R8
  tx_pkt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_hdr |-> tx_pkts < NW'(PKTS));
  // R1
  slice_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_tx_valid && !tx_slend |=> link_tx_valid);

  // ---------------- deserializer ----------------
  logic [WORD_W-1:0] rx_sh;
  logic [SIW-1:0] rx_sidx;
  logic rx_hdr, rx_keep;
  logic [LEN_W-1:0] rx_rem, rx_hlen;
  logic [31:0] rx_crc;

  wire [WORD_W-1:0] rx_word = {link_rx_data, rx_sh[WORD_W-1:LANES]};
  wire rx_wend = link_rx_valid && (rx_sidx == SL_LAST);
  wire rx_cur_last = rx_hdr ? (rx_hlen == '0) : (rx_rem == LEN_W'(1));
  wire rx_zone = rx_cur_last && (rx_sidx >= SIW'(CRC_START));
  wire crc_ok = (rx_word[WORD_W-1 -: 32] == rx_crc);

  // ---------------- receive queue ----------------
  logic [WORD_W:0] rq [QW];
  logic [PW-1:0] rq_wp, rq_cp, rq_rp;
  logic [CW-1:0] rq_cw, rq_pw;
  logic [NW-1:0] rx_pkts;

  wire rx_room = (rx_pkts != NW'(PKTS)) && (int'(rq_cw) + int'(rx_hlen) + 1 <= QW);
  wire rx_take = rx_hdr ? rx_room : rx_keep;
  wire rx_pass = rx_wend && rx_take && rx_cur_last && crc_ok;
  wire rx_fail = rx_wend && rx_take && rx_cur_last && !crc_ok;
  wire rx_wr = rx_wend && rx_take && !(rx_cur_last && !crc_ok);
  wire [WORD_W:0] rq_head = rq[rq_rp];

  assign out_valid = (rq_cw != '0);
  assign out_data = rq_head[WORD_W-1:0];
  assign out_last = rq_head[WORD_W];
  wire rd = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rx_wr) rq[rq_wp] <= {rx_cur_last, rx_word};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh <= '0; rx_sidx <= '0; rx_hdr <= 1'b1; rx_keep <= 1'b0;
      rx_rem <= '0; rx_hlen <= '0; rx_crc <= CRC_INIT;
    end else if (link_rx_valid) begin
      rx_sh <= rx_word;
      rx_sidx <= rx_wend ? '0 : rx_sidx + SIW'(1);
      if (!rx_zone)
        rx_crc <= crc_step((rx_hdr && rx_sidx == '0) ? CRC_INIT : rx_crc, link_rx_data);
      if (rx_hdr && rx_sidx == '0) rx_hlen <= link_rx_data[LEN_W-1:0];
      if (rx_wend) begin
        if (rx_hdr) begin
          rx_keep <= rx_room;
          rx_rem <= rx_hlen;
          rx_hdr <= (rx_hlen == '0);
        end else begin
          rx_rem <= rx_rem - LEN_W'(1);
          rx_hdr <= (rx_rem == LEN_W'(1));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_wp <= '0; rq_cp <= '0; rq_rp <= '0; rq_cw <= '0; rq_pw <= '0;
      rx_pkts <= '0; crc_err <= 1'b0;
    end else begin
      if (rx_fail) begin
        rq_wp <= rq_cp;
        rq_pw <= '0;
        crc_err <= 1'b1;
      end else if (rx_pass) begin
        rq_wp <= nxt(rq_wp);
        rq_cp <= nxt(rq_wp);
        rq_pw <= '0;
      end else if (rx_wr) begin
        rq_wp <= nxt(rq_wp);
        rq_pw <= rq_pw + CW'(1);
      end
      if (rd) rq_rp <= nxt(rq_rp);
      rq_cw <= rq_cw + (rx_pass ? rq_pw + CW'(1) : '0) - CW'(rd);
      rx_pkts <= rx_pkts + NW'(rx_pass) - NW'(rd && out_last);
    end
  end

  // R9
  rx_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pass |-> rx_pkts < NW'(PKTS));
  // R5
  out_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rx_pkts != '0);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> crc_err);
endmodule

// File: tb/lane_pkt_link_tb_top.sv
module lane_pkt_link_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam int NVEC = 6;
  // {len[39:36], seed[35:4], input stall cycles[3:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd0, 32'h1234_5678, 4'd0},
    {4'd1, 32'h0BAD_F00D, 4'd0},
    {4'd3, 32'hCAFE_0001, 4'd0},
    {4'd8, 32'h5555_AAAA, 4'd0},
    {4'd5, 32'h0000_0013, 4'd3},
    {4'd2, 32'hFFFF_0000, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid, out_ready, out_last;
  logic link_tx_valid, link_rx_valid, crc_err;
  logic [127:0] in_data, out_data;
  logic [15:0] link_tx_data, link_rx_data, cmask;

  always #(CLK_P / 2) clk = ~clk;

  assign link_rx_valid = link_tx_valid;
  assign link_rx_data = link_tx_data ^ (link_tx_valid ? cmask : 16'h0);

  lane_pkt_link dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .link_tx_valid(link_tx_valid), .link_tx_data(link_tx_data),
    .link_rx_valid(link_rx_valid), .link_rx_data(link_rx_data), .crc_err(crc_err)
  );

  int nchk = 0, nbad = 0;
  bit finished = 0, saw_full = 0;
  logic [127:0] sendw [0:8];
  logic [127:0] expw [0:8];
  logic [127:0] bexp [0:23];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkword(input logic [31:0] s, input int i);
    return {s + 32'(i), ~s ^ 32'(i * 7), s * 32'd3 + 32'(i), s ^ 32'hA5A5_0000 ^ 32'(i)};
  endfunction

  function automatic logic [31:0] pkt_crc(input int len);
    logic [31:0] c = '1;
    for (int w = 0; w <= len; w++)
      for (int b = 0; b < 128; b++) begin
        if (!(w == len && b >= 96)) begin
          if (c[31] ^ expw[w][b]) c = {c[30:0], 1'b0} ^ POLY;
          else c = {c[30:0], 1'b0};
        end
      end
    return c;
  endfunction

  task automatic build(input int len, input logic [31:0] seed);
    for (int i = 0; i <= len; i++) begin
      sendw[i] = mkword(seed, i);
      if (i == 0) sendw[i][3:0] = 4'(len);
      expw[i] = sendw[i];
    end
    sendw[len][127:96] = 32'hDEAD_BEEF ^ seed;
    expw[len][127:96] = pkt_crc(len);
  endtask

  task automatic send_word(input logic [127:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    while (!in_ready) begin
      saw_full = 1;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic send_pkt(input int len, input int stall);
    for (int i = 0; i <= len; i++) begin
      send_word(sendw[i]);
      if (stall > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (stall - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // called at a negedge with out_ready low; returns at a negedge
  task automatic recv_pkt(input int len, input string tag);
    int t = 0;
    logic [127:0] held;
    while (!out_valid && t < 3000) begin @(negedge clk); t++; end
    chk(out_valid, "R5", {tag, " packet visible"}, 128'(out_valid), 128'd1);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == held, "R10", {tag, " held while stalled"}, out_data, held);
    out_ready = 1'b1;
    for (int w = 0; w <= len; w++) begin
      t = 0;
      while (!out_valid && t < 3000) begin @(negedge clk); t++; end
      chk(out_data == expw[w], (w == len) ? "R3" : "R2", {tag, " word data"}, out_data, expw[w]);
      chk(out_last == (w == len), "R2", {tag, " last flag"}, 128'(out_last), 128'(w == len));
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++; nchk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0; cmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(in_ready == 1'b1, "R11", "reset in_ready", 128'(in_ready), 128'd1);
    chk(out_valid == 1'b0, "R11", "reset out_valid", 128'(out_valid), 128'd0);
    chk(link_tx_valid == 1'b0, "R11", "reset link_tx_valid", 128'(link_tx_valid), 128'd0);
    chk(crc_err == 1'b0, "R11", "reset crc_err", 128'(crc_err), 128'd0);

    // table of packets: R2, R3, R7, R10
    for (int v = 0; v < NVEC; v++) begin
      build(int'(VEC[v][39:36]), VEC[v][35:4]);
      send_pkt(int'(VEC[v][39:36]), int'(VEC[v][3:0]));
      recv_pkt(int'(VEC[v][39:36]), "table");
    end

    // R4 / R1 / R7 / R5: header alone, payload held back
    build(2, 32'h7777_1111);
    send_word(sendw[0]);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(link_tx_valid == 1'b1, "R4", "lanes start after header", 128'(link_tx_valid), 128'd1);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk(link_tx_valid && link_tx_data == sendw[0][16*k +: 16], "R1", "header slice",
          128'(link_tx_data), 128'(sendw[0][16*k +: 16]));
    end
    @(negedge clk);
    chk(link_tx_valid == 1'b0, "R7", "idle inserted on stall", 128'(link_tx_valid), 128'd0);
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "partial packet withheld", 128'(out_valid), 128'd0);
    send_word(sendw[1]);
    send_word(sendw[2]);
    @(negedge clk);
    in_valid = 1'b0;
    recv_pkt(2, "cut-through");

    // R8 / R9: burst of header-only packets with output stalled
    saw_full = 0;
    for (int p = 0; p < 24; p++) begin
      build(0, 32'h0100_0000 + 32'(p * 17));
      bexp[p] = expw[0];
      send_word(sendw[0]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(saw_full == 1, "R8", "in_ready dropped at 16 queued", 128'(saw_full), 128'd1);
    repeat (400) @(negedge clk);
    for (int p = 0; p < 16; p++) begin
      expw[0] = bexp[p];
      recv_pkt(0, "burst");
    end
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "overflow packets discarded", 128'(out_valid), 128'd0);
    chk(crc_err == 1'b0, "R9", "no error on discard", 128'(crc_err), 128'd0);

    // R6: corrupted packet dropped, flag sticky
    cmask = 16'h0100;
    build(1, 32'h3141_5926);
    send_pkt(1, 0);
    repeat (100) @(negedge clk);
    cmask = 16'h0000;
    chk(out_valid == 1'b0, "R6", "bad packet dropped", 128'(out_valid), 128'd0);
    chk(crc_err == 1'b1, "R6", "crc_err raised", 128'(crc_err), 128'd1);
    build(3, 32'h2718_2818);
    send_pkt(3, 2);
    recv_pkt(3, "after error");
    chk(crc_err == 1'b1, "R6", "crc_err sticky", 128'(crc_err), 128'd1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule